// File: doc/BRIEF.md
# Stack Push/Pop Multiple Sequencer

This block runs multi-register transfers between a register file and memory, one 32-bit word per cycle. It serves four operations. Push stores a list of low registers and, optionally, the link register below the stack pointer. Pop reloads a list of low registers and, optionally, the program counter from the stack pointer upward. Store-multiple and load-multiple do the same kind of transfer from a base register, and their addresses rise with each word.

A caller presents the operation, the 8-bit low-register list, the extra-slot flag, the current stack pointer or base value, and the base register number, and pulses `start`. The sequencer then handles the memory request/ready handshake. It drives a register-file read index for stores and a register-file write port for loads. It ends with a single write-back of the new stack pointer or base value, and the cycle after that it pulses `done`. The register file, the memory and any pipeline refill after a program-counter load are outside this block.

Top module: `stack_xfer_seq`

## Requirements
- R1: Selected registers are transferred in ascending register-number order, scanning list bit 0 first, and each transfer uses an address 4 above the previous one.
- R2: `op` encodes 00 push, 01 pop, 10 store-multiple, 11 load-multiple (bit 0 set means load). The first push address is `base_in` minus 4 times (set list bits plus extra flag). Every other operation starts at `base_in`.
- R3: With `extra_slot` set, one extra word goes last. Push stores register 14 (`rf_rd_idx` = 14) and pop loads register 15 (`rf_wr_idx` = 15).
- R4: At the end, `upd_we` pulses for one cycle. For push, `upd_value` is `base_in` minus 4 times the transfer count and `upd_idx` is 13. Pop gives `base_in` plus 4 times the count with `upd_idx` 13. The multiple forms give `base_in` plus 4 times the count with `upd_idx` = {0, `base_sel`}.
- R5: Load operations spend exactly one cycle with no request between the last accepted transfer and `upd_we`. For store operations, `upd_we` follows in the next cycle.
- R6: `mem_seq` is low on the first request of a sequence and high on every later one.
- R7: A sequence with no words to move pulses `done` in the cycle after `start`, with no memory request and no `upd_we`.
- R8: `busy` is high from the cycle after `start` through the `upd_we` cycle. `done` is a one-cycle pulse in the cycle after `upd_we`, with `busy` low.
- R9: While `mem_ready` is low, the request, its address and its data stay unchanged.
- R10: A `start` pulse that arrives while a sequence is running is ignored.
- R11: `extra_slot` has no effect on store-multiple and load-multiple.
- R12: Stores drive `mem_wdata` from `rf_rd_data` for the register named on `rf_rd_idx`. Loads raise `rf_we` in the accepted cycle, with `rf_wr_data` = `mem_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| op | input | 2 | Operation code, see R2 |
| extra_slot | input | 1 | Add link-register / program-counter slot |
| reg_list | input | LIST_W | Low-register select mask |
| base_in | input | AW | Stack pointer or base register value |
| base_sel | input | 3 | Base register number for multiple forms |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_seq | output | 1 | Request is sequential to the previous one |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Store data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | DW | Load data, valid with mem_ready |
| rf_rd_idx | output | 4 | Register-file read index |
| rf_rd_data | input | DW | Register-file read data |
| rf_we | output | 1 | Register-file write enable |
| rf_wr_idx | output | 4 | Register-file write index |
| rf_wr_data | output | DW | Register-file write data |
| upd_we | output | 1 | Stack-pointer / base write-back strobe |
| upd_idx | output | 4 | Register written back |
| upd_value | output | AW | Written-back value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The first request appears one cycle after `start` is sampled. Each transfer then takes one cycle plus the stall cycles the bench inserts. Load forms add one gap cycle, `upd_we` follows, and `done` comes one cycle later. For n words and w stalls per word, `done` is therefore due n(w+1)+2 cycles after `start`, plus 1 for loads, and just 1 cycle after `start` for empty sequences. The bench drives inputs and reads outputs on the falling edge. It counts cycles from the `start` edge and compares each accepted transfer, the write-back cycle and the `done` cycle against these counts, which it computes itself.

// File: rtl/seq_pkg.sv
package seq_pkg;
   typedef enum logic [2:0] {
      S_IDLE = 3'd0,
      S_XFER = 3'd1,
      S_GAP  = 3'd2,
      S_UPD  = 3'd3,
      S_DONE = 3'd4
   } seq_state_e;

   localparam logic [3:0] REG_SP = 4'd13;
   localparam logic [3:0] REG_LR = 4'd14;
   localparam logic [3:0] REG_PC = 4'd15;
endpackage

// File: rtl/seq_lowbit.sv
module seq_lowbit #(
   parameter int W = 8,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);
   logic [W-1:0] below;

   generate
      for (genvar i = 0; i < W; i++) begin : g_below
         if (i == 0) begin : g_first
            assign below[i] = 1'b0;
         end else begin : g_rest
            assign below[i] = below[i-1] | vec[i-1];
         end
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int i = 0; i < W; i++) begin
         if (vec[i] && !below[i]) idx = IW'(i);
      end
   end

   assign found = |vec;
endmodule

// File: rtl/seq_span.sv
module seq_span #(
   parameter int AW     = 32,
   parameter int LIST_W = 8,
   localparam int CNT_W = $clog2(LIST_W + 2)
) (
   input  logic [LIST_W-1:0] list,
   input  logic              extra,
   input  logic              descend,
   input  logic [AW-1:0]     base,
   output logic [AW-1:0]     first_addr,
   output logic [AW-1:0]     final_value,
   output logic              empty
);
   logic [CNT_W-1:0] cnt;
   logic [AW-1:0]    span;

   assign cnt         = CNT_W'($countones(list)) + CNT_W'(extra);
   assign span        = AW'(cnt) << 2;
   assign empty       = (cnt == '0);
   assign first_addr  = descend ? (base - span) : base;
   assign final_value = descend ? (base - span) : (base + span);
endmodule

// File: rtl/stack_xfer_seq.sv
module stack_xfer_seq
   import seq_pkg::*;
#(
   parameter int AW     = 32,
   parameter int DW     = 32,
   parameter int LIST_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op,
   input  logic              extra_slot,
   input  logic [LIST_W-1:0] reg_list,
   input  logic [AW-1:0]     base_in,
   input  logic [2:0]        base_sel,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_seq,
   output logic [AW-1:0]     mem_addr,
   output logic [DW-1:0]     mem_wdata,
   input  logic              mem_ready,
   input  logic [DW-1:0]     mem_rdata,
   output logic [3:0]        rf_rd_idx,
   input  logic [DW-1:0]     rf_rd_data,
   output logic              rf_we,
   output logic [3:0]        rf_wr_idx,
   output logic [DW-1:0]     rf_wr_data,
   output logic              upd_we,
   output logic [3:0]        upd_idx,
   output logic [AW-1:0]     upd_value,
   output logic              busy,
   output logic              done
);
   localparam int          IW        = (LIST_W > 1) ? $clog2(LIST_W) : 1;
   localparam logic [AW-1:0] WORD_STEP = AW'(4);

   generate
      if (LIST_W < 2 || LIST_W > 8) begin : g_bad_list
         $error("LIST_W must lie in 2..8");
      end
      if (AW < 8 || DW < 8) begin : g_bad_width
         $error("AW and DW must be at least 8");
      end
   endgenerate

   seq_state_e        state_q;
   logic [LIST_W-1:0] pend_q;
   logic              extra_q;
   logic              load_q;
   logic              seq_q;
   logic [AW-1:0]     addr_q;
   logic [AW-1:0]     final_q;
   logic [3:0]        uidx_q;

   logic              extra_eff;
   logic [AW-1:0]     span_first;
   logic [AW-1:0]     span_final;
   logic              span_empty;
   logic              low_found;
   logic [IW-1:0]     low_idx;
   logic [LIST_W-1:0] pend_next;
   logic [3:0]        cur_idx;
   logic              xfer_last;

   assign extra_eff = extra_slot & ~op[1];

   seq_span #(.AW(AW), .LIST_W(LIST_W)) u_span (
      .list        (reg_list),
      .extra       (extra_eff),
      .descend     (op == 2'b00),
      .base        (base_in),
      .first_addr  (span_first),
      .final_value (span_final),
      .empty       (span_empty)
   );

   seq_lowbit #(.W(LIST_W)) u_low (
      .vec   (pend_q),
      .found (low_found),
      .idx   (low_idx)
   );

   assign pend_next = pend_q & (pend_q - LIST_W'(1));
   assign cur_idx   = low_found ? 4'(low_idx) : (load_q ? REG_PC : REG_LR);
   assign xfer_last = low_found ? ((pend_next == '0) && !extra_q) : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         pend_q  <= '0;
         extra_q <= 1'b0;
         load_q  <= 1'b0;
         seq_q   <= 1'b0;
         addr_q  <= '0;
         final_q <= '0;
         uidx_q  <= '0;
      end else begin
         case (state_q)
            S_IDLE: if (start) begin
               load_q  <= op[0];
               pend_q  <= reg_list;
               extra_q <= extra_eff;
               addr_q  <= span_first;
               final_q <= span_final;
               uidx_q  <= op[1] ? {1'b0, base_sel} : REG_SP;
               seq_q   <= 1'b0;
               state_q <= span_empty ? S_DONE : S_XFER;
            end
            S_XFER: if (mem_ready) begin
               addr_q <= addr_q + WORD_STEP;
               seq_q  <= 1'b1;
               if (low_found) pend_q  <= pend_next;
               else           extra_q <= 1'b0;
               if (xfer_last) state_q <= load_q ? S_GAP : S_UPD;
            end
            S_GAP:   state_q <= S_UPD;
            S_UPD:   state_q <= S_DONE;
            S_DONE:  state_q <= S_IDLE;
            default: state_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req    = (state_q == S_XFER);
      mem_we     = mem_req && !load_q;
      mem_seq    = seq_q;
      mem_addr   = addr_q;
      rf_rd_idx  = mem_req ? cur_idx : 4'd0;
      mem_wdata  = rf_rd_data;
      rf_we      = mem_req && mem_ready && load_q;
      rf_wr_idx  = cur_idx;
      rf_wr_data = mem_rdata;
      upd_we     = (state_q == S_UPD);
      upd_idx    = uidx_q;
      upd_value  = final_q;
      busy       = (state_q == S_XFER) || (state_q == S_GAP) || (state_q == S_UPD);
      done       = (state_q == S_DONE);
   end

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ready) |=> (!mem_req || mem_addr == $past(mem_addr) + WORD_STEP)); // R1
   AST_LOAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_we && load_q) |-> !$past(mem_req)); // R5
   AST_FIRST_NONSEQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> !mem_seq); // R6
   AST_LATER_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ready) |=> (!mem_req || mem_seq)); // R6
   AST_DONE_AFTER_UPD: assert property (@(posedge clk) disable iff (!rst_n)
      upd_we |=> done); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !rf_we && !upd_we)); // R8
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R9
endmodule

// File: tb/stack_xfer_seq_tb.sv
module stack_xfer_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = 2'b00;
   logic        extra_slot = 1'b0;
   logic [7:0]  reg_list = 8'h00;
   logic [31:0] base_in = 32'h0;
   logic [2:0]  base_sel = 3'd5;
   logic        mem_req, mem_we, mem_seq;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ready = 1'b0;
   logic [31:0] mem_rdata;
   logic [3:0]  rf_rd_idx;
   logic [31:0] rf_rd_data;
   logic        rf_we;
   logic [3:0]  rf_wr_idx;
   logic [31:0] rf_wr_data;
   logic        upd_we;
   logic [3:0]  upd_idx;
   logic [31:0] upd_value;
   logic        busy, done;

   int tests = 0;
   int fails = 0;
   int total_cyc = 0;

   function automatic logic [31:0] regval(input logic [3:0] i);
      return 32'hA000_0000 + 32'(i) * 32'h111;
   endfunction

   function automatic logic [31:0] memval(input logic [31:0] a);
      return {a[15:0], ~a[15:0]};
   endfunction

   assign rf_rd_data = regval(rf_rd_idx);
   assign mem_rdata  = memval(mem_addr);

   always #5 clk = ~clk;

   stack_xfer_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .extra_slot(extra_slot),
      .reg_list(reg_list), .base_in(base_in), .base_sel(base_sel),
      .mem_req(mem_req), .mem_we(mem_we), .mem_seq(mem_seq), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
      .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data), .rf_we(rf_we),
      .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data), .upd_we(upd_we),
      .upd_idx(upd_idx), .upd_value(upd_value), .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      total_cyc++;
      if (total_cyc > 100000) begin
         fails++;
         $display("FAIL R8 watchdog act=%0d exp=%0d", total_cyc, 100000);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   // {op, extra, list, base, waits}
   localparam int NV = 8;
   localparam logic [44:0] VEC [NV] = '{
      {2'b00, 1'b0, 8'h0F, 32'h0000_1000, 2'd0},
      {2'b00, 1'b1, 8'hA5, 32'h0000_2000, 2'd1},
      {2'b01, 1'b0, 8'h81, 32'h0000_3000, 2'd0},
      {2'b01, 1'b1, 8'h3C, 32'h0000_3100, 2'd2},
      {2'b10, 1'b0, 8'hFF, 32'h0000_4000, 2'd0},
      {2'b11, 1'b1, 8'h12, 32'h0000_5000, 2'd1},
      {2'b00, 1'b1, 8'h00, 32'h0000_6000, 2'd0},
      {2'b01, 1'b1, 8'h00, 32'h0000_7000, 2'd3}
   };

   task automatic run_case(input logic [1:0] c_op, input logic c_ex, input logic [7:0] c_list,
                           input logic [31:0] c_base, input int waits, input bit mid_start);
      logic [3:0]  ids [10];
      int          n = 0;
      logic        ld = c_op[0];
      logic [31:0] first, fin;
      logic [3:0]  uidx;
      int          xi = 0;
      int          wc = 0;
      int          cyc = 1;
      int          last_cyc = 0;
      int          upd_cyc = -1;
      int          exp_done;
      for (int b = 0; b < 8; b++) if (c_list[b]) begin ids[n] = 4'(b); n++; end
      if (c_ex && !c_op[1]) begin ids[n] = ld ? 4'd15 : 4'd14; n++; end
      first    = (c_op == 2'b00) ? c_base - 32'(4 * n) : c_base;
      fin      = (c_op == 2'b00) ? c_base - 32'(4 * n) : c_base + 32'(4 * n);
      uidx     = c_op[1] ? {1'b0, base_sel} : 4'd13;
      exp_done = (n == 0) ? 1 : n * (waits + 1) + (ld ? 1 : 0) + 2;

      @(negedge clk);
      op = c_op; extra_slot = c_ex; reg_list = c_list; base_in = c_base; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && cyc < 200) begin
         if (mid_start && cyc == 2) begin
            start = 1'b1; op = 2'b01; reg_list = 8'hFF; base_in = 32'h0000_9000;
         end else begin
            start = 1'b0;
         end
         chk(busy, "R8 busy during sequence", 32'(busy), 32'd1);
         if (mem_req) begin
            if (xi >= n) begin
               chk(1'b0, "R7/R10 extra request", 32'(xi), 32'(n));
            end else if (wc < waits) begin
               wc++;
               mem_ready = 1'b0;
            end else begin
               wc = 0;
               mem_ready = 1'b1;
               #1;
               chk(mem_addr == first + 32'(4 * xi), "R1/R2 address", mem_addr, first + 32'(4 * xi));
               chk(mem_seq == (xi != 0), "R6 seq flag", 32'(mem_seq), 32'(xi != 0));
               chk(mem_we == !ld, "R2 direction", 32'(mem_we), 32'(!ld));
               if (!ld) begin
                  chk(rf_rd_idx == ids[xi], "R1/R3 store register", 32'(rf_rd_idx), 32'(ids[xi]));
                  chk(mem_wdata == regval(ids[xi]), "R12 store data", mem_wdata, regval(ids[xi]));
               end else begin
                  chk(rf_we && rf_wr_idx == ids[xi], "R1/R3 load register",
                      {27'd0, rf_we, rf_wr_idx}, {27'd0, 1'b1, ids[xi]});
                  chk(rf_wr_data == memval(first + 32'(4 * xi)), "R12 load data",
                      rf_wr_data, memval(first + 32'(4 * xi)));
               end
               xi++;
               last_cyc = cyc;
            end
         end
         if (upd_we) begin
            upd_cyc = cyc;
            chk(upd_value == fin, "R4 update value", upd_value, fin);
            chk(upd_idx == uidx, "R4 update index", 32'(upd_idx), 32'(uidx));
            chk(xi == n, "R4 transfer count", 32'(xi), 32'(n));
         end
         @(negedge clk);
         mem_ready = 1'b0;
         cyc++;
      end
      start = 1'b0;
      chk(cyc == exp_done, "R8 done cycle", 32'(cyc), 32'(exp_done));
      chk(done && !busy, "R8 done with busy low", {30'd0, done, busy}, 32'd2);
      if (n == 0) begin
         chk(upd_cyc == -1 && xi == 0, "R7 empty no access", 32'(xi), 32'd0);
      end else begin
         chk(upd_cyc == last_cyc + (ld ? 2 : 1), "R5 idle gap", 32'(upd_cyc), 32'(last_cyc + (ld ? 2 : 1)));
      end
      @(negedge clk);
      chk(!done, "R8 done pulse width", 32'(done), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !done && !mem_req && !upd_we && !rf_we, "R8 reset state",
          {27'd0, busy, done, mem_req, upd_we, rf_we}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         run_case(VEC[v][44:43], VEC[v][42], VEC[v][41:34], VEC[v][33:2], int'(VEC[v][1:0]), 1'b0);
      end

      // R7: empty push, no extra slot
      run_case(2'b00, 1'b0, 8'h00, 32'h0000_8000, 0, 1'b0);
      // R11 and R7: load-multiple with extra flag and empty list stays empty
      run_case(2'b11, 1'b1, 8'h00, 32'h0000_8100, 0, 1'b0);
      // R11: store-multiple with extra flag moves only listed registers
      run_case(2'b10, 1'b1, 8'h40, 32'h0000_8200, 1, 1'b0);
      // R10: start while running is ignored
      run_case(2'b00, 1'b0, 8'h0F, 32'h0000_1000, 0, 1'b1);
      // R9: long stalls on a push with extra slot
      run_case(2'b00, 1'b1, 8'h80, 32'h0000_A000, 3, 1'b0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule